// File: doc/BRIEF.md
# Dual-Bank Fast/Normal Interrupt Request Controller

This block collects level-sensitive interrupt sources from two banks and drives two processor request lines. Each source has an enable bit, which masks it, and a steering bit, which sends it to the fast request line (`fiq_o`) or to the normal request line (`irq_o`). A third output, `wake_o`, tells a halted core that something needs attention. This output uses a separate idle mask, so a source can wake the core without being enabled for interrupts.

Software reaches the register file in two ways. The first is a 32-bit memory-mapped port with byte addresses. The second is a coprocessor-style port that selects a register by a small index. Both ports decode to the same storage. The coprocessor port exposes only the subset of registers that its index map lists. A read-only summary register reports the lowest-numbered active source on each request line. All outputs, including read data, are registered.

Top module: `dual_bank_intc`

## Requirements
- R1: The block has two banks of 32 sources each. Source n of `src_i` belongs to bank n/32. Memory-port byte offsets are:
  - IRQ-pending: 0x00 (bank 0) and 0x04 (bank 1).
  - FIQ-pending: 0x08 and 0x0C.
  - Raw pending: 0x10 and 0x14.
  - Enable: 0x18 and 0x1C.
  - Steering: 0x20 and 0x24.
  - Idle mask: 0x28 and 0x2C.
  - Highest-pending summary: 0x30.
  - Any other offset reads zero.
  Enable, steering and idle-mask registers are read/write. Read data appears on the clock edge after the request.
- R2: A source is active only when its pending bit and its enable bit are both 1. With every enable bit 0, `fiq_o` and `irq_o` stay low.
- R3: `fiq_o` is high when any active source in either bank has its steering bit at 1. It follows the pin with two register stages.
- R4: `irq_o` is high when any active source in either bank has its steering bit at 0. It has the same latency as `fiq_o`.
- R5: While `core_halted_i` is high, `wake_o` is high when (pending AND (enable OR idle mask)) is nonzero in either bank. While `core_halted_i` is low, `wake_o` is low.
- R6: A pending bit is the live level of its pin, sampled each clock. It clears when the pin falls, with no latching. The raw-pending words read these bits.
- R7: The IRQ-pending readout is active AND NOT steering, and the FIQ-pending readout is active AND steering. Both are read-only, and writes to them change nothing.
- R8: The coprocessor index selects a register as follows: 0 IRQ-pending bank 0, 1 enable bank 0, 2 steering bank 0, 3 FIQ-pending bank 0, 4 priority, 5 highest-pending, 6 IRQ-pending bank 1, 7 enable bank 1, 8 steering bank 1, 9 FIQ-pending bank 1, 10 priority. Each access is a full 32-bit access to the same storage the memory port reaches.
- R9: A coprocessor index above 10 reads zero and its writes are ignored. Both priority slots (indices 4 and 10) read zero and ignore writes.
- R10: The highest-pending summary is laid out as follows:
  - bit 31: valid flag for an active FIQ-steered source.
  - bits 21:16: number (0..63) of the lowest-numbered active FIQ-steered source.
  - bit 15: valid flag for an active IRQ-steered source.
  - bits 5:0: number of the lowest-numbered active IRQ-steered source.
  - All other bits are zero.
- R11: Synchronous reset clears the following:
  - all pending, enable, steering and idle-mask bits;
  - all three request outputs;
  - both read-data outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Level-sensitive interrupt sources, bank 0 in bits 31:0 |
| core_halted_i | input | 1 | Core is halted; enables the wake output |
| bus_sel_i | input | 1 | Memory port access strobe |
| bus_we_i | input | 1 | Memory port write (1) or read (0) |
| bus_addr_i | input | 8 | Memory port byte address |
| bus_wdata_i | input | 32 | Memory port write data |
| bus_rdata_o | output | 32 | Memory port read data, one cycle after the request |
| cp_valid_i | input | 1 | Coprocessor access strobe |
| cp_we_i | input | 1 | Coprocessor write (1) or read (0) |
| cp_idx_i | input | 4 | Coprocessor register index |
| cp_wdata_i | input | 32 | Coprocessor write data |
| cp_rdata_o | output | 32 | Coprocessor read data, one cycle after the request |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |
| wake_o | output | 1 | Wake request for a halted core |

## Verification
Some rules are checked by the embedded properties on every cycle:
- the reset state of the bank registers;
- the quiet request lines when nothing is enabled;
- a silent `wake_o` while the core runs;
- the register contents, which do not change on out-of-range coprocessor writes;
- an enable write landing one cycle later;
- `fiq_o` never rising without some steering bit set.

Other behaviour only the bench scenarios can show:
- the actual steering of specific sources and the lowest-number search across banks;
- the split of the pending readouts;
- the coprocessor index map resolving to the same storage as the memory port;
- the idle-mask wake path;
- live-level pending.

// File: rtl/dual_bank_intc_pkg.sv
package dual_bank_intc_pkg;
  localparam int NBANK = 2;

  typedef enum logic [3:0] {
    RK_NONE, RK_IRQP, RK_FIQP, RK_RAW, RK_EN, RK_SEL, RK_IDLE, RK_HIGH, RK_PRIO
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e kind;
    logic      bank;
  } reg_ref_t;

  // Coprocessor index map; the order is fixed by the software view.
  function automatic reg_ref_t decode_cp(input logic [3:0] idx);
    reg_ref_t r;
    r.bank = (idx >= 4'd6);
    case (idx)
      4'd0, 4'd6:  r.kind = RK_IRQP;
      4'd1, 4'd7:  r.kind = RK_EN;
      4'd2, 4'd8:  r.kind = RK_SEL;
      4'd3, 4'd9:  r.kind = RK_FIQP;
      4'd4, 4'd10: r.kind = RK_PRIO;
      4'd5:        r.kind = RK_HIGH;
      default:     r.kind = RK_NONE;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/intc_first_set.sv
module intc_first_set #(
  parameter int W  = 64,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src_i,
  input  logic         en_we,
  input  logic         sel_we,
  input  logic         idle_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] sel_o,
  output logic [W-1:0] idle_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= '0;
      en_o   <= '0;
      sel_o  <= '0;
      idle_o <= '0;
    end else begin
      pend_o <= src_i;
      if (en_we)   en_o   <= wdata;
      if (sel_we)  sel_o  <= wdata;
      if (idle_we) idle_o <= wdata;
    end
  end

  // R11: registers come out of reset empty
  p_reset_clear_r11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pend_o == '0 && en_o == '0 && sel_o == '0 && idle_o == '0));

  // R1: an enable write is visible on the following cycle
  p_en_write_r1: assert property (@(posedge clk) disable iff (rst)
    en_we |=> (en_o == $past(wdata)));
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import dual_bank_intc_pkg::*;
#(
  parameter int BANK_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NBANK*BANK_W-1:0] src_i,
  input  logic                    core_halted_i,
  input  logic                    bus_sel_i,
  input  logic                    bus_we_i,
  input  logic [ADDR_W-1:0]       bus_addr_i,
  input  logic [BANK_W-1:0]       bus_wdata_i,
  output logic [BANK_W-1:0]       bus_rdata_o,
  input  logic                    cp_valid_i,
  input  logic                    cp_we_i,
  input  logic [3:0]              cp_idx_i,
  input  logic [BANK_W-1:0]       cp_wdata_i,
  output logic [BANK_W-1:0]       cp_rdata_o,
  output logic                    fiq_o,
  output logic                    irq_o,
  output logic                    wake_o
);
  localparam int NSRC  = NBANK * BANK_W;
  localparam int IDX_W = $clog2(NSRC);
  localparam int HALF  = BANK_W / 2;
  localparam int WORD_W = ADDR_W - 2;

  logic [BANK_W-1:0] pend [NBANK];
  logic [BANK_W-1:0] en   [NBANK];
  logic [BANK_W-1:0] sel  [NBANK];
  logic [BANK_W-1:0] idle [NBANK];
  logic [NSRC-1:0]   pend_flat, en_flat, sel_flat, idle_flat, act_flat;

  reg_ref_t          mmio_ref, cp_ref, wr_ref;
  logic              wr_go;
  logic [BANK_W-1:0] wr_data;

  function automatic reg_ref_t decode_mmio(input logic [WORD_W-1:0] word);
    reg_ref_t r;
    r.bank = word[0];
    r.kind = RK_NONE;
    if (word == WORD_W'(12)) r.kind = RK_HIGH;
    else if (word < WORD_W'(12)) begin
      case (word[3:1])
        3'd0: r.kind = RK_IRQP;
        3'd1: r.kind = RK_FIQP;
        3'd2: r.kind = RK_RAW;
        3'd3: r.kind = RK_EN;
        3'd4: r.kind = RK_SEL;
        default: r.kind = RK_IDLE;
      endcase
    end
    return r;
  endfunction

  always_comb begin
    mmio_ref = decode_mmio(bus_addr_i[ADDR_W-1:2]);
    cp_ref   = decode_cp(cp_idx_i);
    // Memory port wins when both paths write in the same cycle.
    if (bus_sel_i && bus_we_i) begin
      wr_go = 1'b1; wr_ref = mmio_ref; wr_data = bus_wdata_i;
    end else begin
      wr_go = cp_valid_i && cp_we_i; wr_ref = cp_ref; wr_data = cp_wdata_i;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    intc_bank #(.W(BANK_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .src_i   (src_i[b*BANK_W +: BANK_W]),
      .en_we   (wr_go && wr_ref.kind == RK_EN   && wr_ref.bank == 1'(b)),
      .sel_we  (wr_go && wr_ref.kind == RK_SEL  && wr_ref.bank == 1'(b)),
      .idle_we (wr_go && wr_ref.kind == RK_IDLE && wr_ref.bank == 1'(b)),
      .wdata   (wr_data),
      .pend_o  (pend[b]),
      .en_o    (en[b]),
      .sel_o   (sel[b]),
      .idle_o  (idle[b])
    );
    assign pend_flat[b*BANK_W +: BANK_W] = pend[b];
    assign en_flat[b*BANK_W +: BANK_W]   = en[b];
    assign sel_flat[b*BANK_W +: BANK_W]  = sel[b];
    assign idle_flat[b*BANK_W +: BANK_W] = idle[b];
  end

  assign act_flat = pend_flat & en_flat;

  logic             fiq_found, irq_found;
  logic [IDX_W-1:0] fiq_idx, irq_idx;

  intc_first_set #(.W(NSRC), .IW(IDX_W)) u_first_fiq (
    .vec_i (act_flat & sel_flat), .found_o (fiq_found), .idx_o (fiq_idx));
  intc_first_set #(.W(NSRC), .IW(IDX_W)) u_first_irq (
    .vec_i (act_flat & ~sel_flat), .found_o (irq_found), .idx_o (irq_idx));

  logic [BANK_W-1:0] high_word;
  always_comb begin
    high_word = '0;
    high_word[BANK_W-1]            = fiq_found;
    high_word[HALF +: IDX_W]       = fiq_idx;
    high_word[HALF-1]              = irq_found;
    high_word[IDX_W-1:0]           = irq_idx;
  end

  function automatic logic [BANK_W-1:0] pick(input reg_ref_t r);
    logic [BANK_W-1:0] a;
    a = pend[r.bank] & en[r.bank];
    case (r.kind)
      RK_IRQP: return a & ~sel[r.bank];
      RK_FIQP: return a & sel[r.bank];
      RK_RAW:  return pend[r.bank];
      RK_EN:   return en[r.bank];
      RK_SEL:  return sel[r.bank];
      RK_IDLE: return idle[r.bank];
      RK_HIGH: return high_word;
      default: return '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      fiq_o       <= 1'b0;
      irq_o       <= 1'b0;
      wake_o      <= 1'b0;
      bus_rdata_o <= '0;
      cp_rdata_o  <= '0;
    end else begin
      fiq_o       <= |(act_flat & sel_flat);
      irq_o       <= |(act_flat & ~sel_flat);
      wake_o      <= core_halted_i && (|(pend_flat & (en_flat | idle_flat)));
      bus_rdata_o <= (bus_sel_i && !bus_we_i) ? pick(mmio_ref) : '0;
      cp_rdata_o  <= (cp_valid_i && !cp_we_i) ? pick(cp_ref) : '0;
    end
  end

  // R2: nothing enabled keeps both request lines low
  p_masked_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (en_flat == '0) |=> (!fiq_o && !irq_o));

  // R3: the fast line needs at least one steering bit set
  p_fiq_needs_steer_r3: assert property (@(posedge clk) disable iff (rst)
    fiq_o |-> ($past(sel_flat) != '0));

  // R5: a running core never sees a wake request
  p_awake_no_wake_r5: assert property (@(posedge clk) disable iff (rst)
    !core_halted_i |=> !wake_o);

  // R9: out-of-range coprocessor writes leave storage untouched
  p_cp_bad_idx_r9: assert property (@(posedge clk) disable iff (rst)
    (cp_valid_i && cp_we_i && cp_idx_i > 4'd10 && !(bus_sel_i && bus_we_i))
      |=> ($stable(en_flat) && $stable(sel_flat) && $stable(idle_flat)));
endmodule

// File: tb/dual_bank_intc_tb_top.sv
module dual_bank_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src = '0;
  logic        halted = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        cp_valid = 1'b0, cp_we = 1'b0;
  logic [3:0]  cp_idx = '0;
  logic [31:0] cp_wdata = '0, cp_rdata;
  logic        fiq, irq, wake;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_bank_intc dut_i (
    .clk(clk), .rst(rst), .src_i(src), .core_halted_i(halted),
    .bus_sel_i(bus_sel), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .cp_valid_i(cp_valid), .cp_we_i(cp_we), .cp_idx_i(cp_idx),
    .cp_wdata_i(cp_wdata), .cp_rdata_o(cp_rdata),
    .fiq_o(fiq), .irq_o(irq), .wake_o(wake)
  );

  // Scoreboard queues
  logic [31:0] exp_q[$];
  bit          path_q[$];
  string       tag_q[$];
  logic        rd_lat = 1'b0;

  always @(posedge clk) rd_lat <= (bus_sel && !bus_we) || (cp_valid && !cp_we);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data when a read result is due
  always @(negedge clk) begin
    if (rd_lat) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 32'd1, 32'd0);
      else begin
        logic [31:0] e; bit p; string t;
        e = exp_q.pop_front(); p = path_q.pop_front(); t = tag_q.pop_front();
        check(t, p ? cp_rdata : bus_rdata, e);
      end
    end
  end

  task automatic mm_wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask
  task automatic mm_rd(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); path_q.push_back(0); tag_q.push_back(t);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0;
  endtask
  task automatic cp_wr(input logic [3:0] i, input logic [31:0] d);
    cp_valid = 1; cp_we = 1; cp_idx = i; cp_wdata = d;
    @(negedge clk); cp_valid = 0; cp_we = 0;
  endtask
  task automatic cp_rd(input logic [3:0] i, input logic [31:0] e, input string t);
    exp_q.push_back(e); path_q.push_back(1); tag_q.push_back(t);
    cp_valid = 1; cp_we = 0; cp_idx = i;
    @(negedge clk); cp_valid = 0;
  endtask
  task automatic settle();
    repeat (2) @(negedge clk);
  endtask
  task automatic lines(input string t, input bit f, input bit i, input bit w);
    check({t, " fiq"}, 32'(fiq), 32'(f));
    check({t, " irq"}, 32'(irq), 32'(i));
    check({t, " wake"}, 32'(wake), 32'(w));
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    lines("R11 reset", 0, 0, 0);
    mm_rd(8'h18, 32'h0, "R11 enable0 after reset");
    // R1 register read/write
    mm_wr(8'h18, 32'h0000_00F0);
    mm_wr(8'h20, 32'h0000_0030);
    mm_rd(8'h18, 32'h0000_00F0, "R1 enable0 readback");
    mm_rd(8'h20, 32'h0000_0030, "R1 steer0 readback");
    mm_rd(8'h34, 32'h0, "R1 unmapped offset");
    // R3/R4 steering: bit4 -> fiq, bit6 -> irq
    src = 64'h50; settle();
    lines("R3 R4 mixed", 1, 1, 0);
    mm_rd(8'h00, 32'h40, "R7 irq pending0");
    mm_rd(8'h08, 32'h10, "R7 fiq pending0");
    mm_rd(8'h10, 32'h50, "R6 raw pending0");
    // R7 writes to read-only views change nothing
    mm_wr(8'h00, 32'hFFFF_FFFF); mm_wr(8'h08, 32'h0);
    mm_rd(8'h00, 32'h40, "R7 irq pending0 after write");
    mm_rd(8'h18, 32'h0000_00F0, "R7 enable0 unchanged");
    // R2 unenabled source only
    src = 64'h1; settle();
    lines("R2 masked source", 0, 0, 0);
    mm_rd(8'h10, 32'h1, "R6 raw shows masked pin");
    // R6 live level clears
    src = 64'h0; settle();
    mm_rd(8'h10, 32'h0, "R6 pending follows pin low");
    // R8 coprocessor path, bank 1
    cp_wr(4'd7, 32'h8000_0000);
    cp_wr(4'd8, 32'h8000_0000);
    mm_rd(8'h1C, 32'h8000_0000, "R8 cp enable1 seen on memory port");
    src = 64'h8000_0000_0000_0000; settle();
    lines("R8 R3 bank1 fiq", 1, 0, 0);
    cp_rd(4'd9, 32'h8000_0000, "R8 cp fiq pending1");
    cp_rd(4'd6, 32'h0, "R8 cp irq pending1");
    cp_rd(4'd1, 32'h0000_00F0, "R8 cp enable0");
    cp_rd(4'd2, 32'h0000_0030, "R8 cp steer0");
    // R10 highest pending
    src = 64'h8000_0000_0000_0050; settle();
    cp_rd(4'd5, 32'h8004_8006, "R10 highest via cp");
    mm_rd(8'h30, 32'h8004_8006, "R10 highest via memory port");
    src = 64'h8000_0000_0000_0000; settle();
    cp_rd(4'd5, 32'h803F_0000, "R10 only bank1 fiq");
    src = 64'h0; settle();
    mm_rd(8'h30, 32'h0, "R10 none active");
    // R9 bad index and priority slots
    cp_wr(4'd12, 32'hFFFF_FFFF);
    cp_wr(4'd4, 32'hFFFF_FFFF);
    cp_rd(4'd12, 32'h0, "R9 bad index reads zero");
    cp_rd(4'd10, 32'h0, "R9 priority slot reads zero");
    mm_rd(8'h18, 32'h0000_00F0, "R9 enable0 unchanged");
    mm_rd(8'h20, 32'h0000_0030, "R9 steer0 unchanged");
    mm_rd(8'h28, 32'h0, "R9 idle0 unchanged");
    // R5 wake path
    src = 64'h2; halted = 0; settle();
    lines("R5 pending unenabled, running", 0, 0, 0);
    mm_wr(8'h28, 32'h2); settle();
    lines("R5 idle mask, running", 0, 0, 0);
    halted = 1; settle();
    lines("R5 idle mask, halted", 0, 0, 1);
    mm_wr(8'h28, 32'h0); settle();
    lines("R5 no wake source, halted", 0, 0, 0);
    src = 64'h20; settle();
    lines("R5 enabled fiq source wakes", 1, 0, 1);
    halted = 0; settle();
    lines("R5 released", 1, 0, 0);
    // R11 reset mid-run
    rst = 1; @(negedge clk); @(negedge clk); rst = 0; src = 64'h0;
    lines("R11 reset mid-run", 0, 0, 0);
    mm_rd(8'h18, 32'h0, "R11 enable0 cleared");
    mm_rd(8'h20, 32'h0, "R11 steer0 cleared");
    repeat (3) @(negedge clk);
    check("scoreboard drained", 32'(exp_q.size()), 32'd0);
    finish_up();
  end
endmodule